// File: doc/BRIEF.md
# Infrared Pulse-Distance Frame Receiver

This block turns a stream of sampled infrared receiver levels into decoded 24-bit frames. It takes one 12-bit sample on each clock where `sample_en` is high. It compares the sample against a fixed threshold, with an optional polarity flip. It then tracks a sliding history of the last 32 decisions to spot the long carrier burst that opens a frame.

After the opening burst has been seen and a fixed settling delay has passed, the receiver measures each carrier-off interval. A long interval gives a 1, a medium one gives a 0, and a very short one is treated as a glitch that abandons the frame. Each carrier-on interval is bounded in length. Once 24 bits are in, the upper 16 bits are run through a CRC-8 and the result is compared with the lowest byte. The decoded category, sender id and amount are then latched, and a one-cycle pulse reports either success or a checksum failure.

The block sits behind a sampling front end that already delivers one sample per enable. Any buffering or channel multiplexing happens outside it.

Top module: `ir_frame_rx`

## Requirements
- R1: A sample counts as active when its unsigned value is strictly above 2048. When `invert` is high, the decision is reversed (at or below 2048 is active).
- R2: While idle, an opening burst is accepted only when at least 24 of the most recent 32 enabled samples, including the current one, are active. A burst of 23 active samples starts nothing.
- R3: After the opening burst is accepted, the next 10 enabled samples are skipped. Carrier-off measurement then starts with an empty bit store, so any off samples inside those 10 are not counted toward the first bit.
- R4: In carrier-off measurement, each inactive sample adds one to a count. The first active sample then ends the interval: a count of 12 or more appends a 1, and a count from 4 to 11 appends a 0.
- R5: A carrier-off count below 4 abandons the frame and returns to idle with no pulse on either result output.
- R6: Inside a carrier-on interval, the active samples after the one that ended the preceding gap are counted. A 13th such sample abandons the frame with no result pulse. The first inactive sample starts a new carrier-off count and is not itself counted.
- R7: Bits are appended at the low end, so the first received bit becomes bit 23 of the word. Bits 23..21 are the category (`frame_type`), 20..13 the id, 12..8 the amount and 7..0 the check byte.
- R8: The check byte is compared with the CRC-8 (polynomial 0x07, initial value 0x00, most significant bit first) of word bits 23..8. On a match, `frame_valid` is high for exactly one clock.
- R9: On a mismatch, `crc_error` is high for exactly one clock. In both cases the decoded fields are updated together with the pulse and then held until the next completed frame.
- R10: Clocks with `sample_en` low do not advance the history, counters or state, whatever `sample_in` carries.
- R11: After reset, both pulses are low, every decoded field is zero and the receiver is idle.
- R12: `frame_is_heal` is high exactly when the latched category equals 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Qualifies `sample_in` for this clock |
| sample_in | input | 12 | Raw receiver sample |
| invert | input | 1 | Reverses the active-level decision |
| frame_valid | output | 1 | One-cycle pulse: frame passed its check |
| crc_error | output | 1 | One-cycle pulse: frame failed its check |
| frame_type | output | 3 | Latched category field |
| frame_id | output | 8 | Latched sender id field |
| frame_amount | output | 5 | Latched amount field |
| frame_is_heal | output | 1 | Latched category equals 1 |

## Verification
The assertions assume that `invert` changes only while the receiver sits idle between frames. They also assume that `sample_en` is the only qualifier of input data, so any value on `sample_in` during a stall must leave the state untouched. The stimulus follows both rules: polarity and level pairs are changed only after a frame has finished and 40 inactive samples have flushed the history. Every stalled clock deliberately carries the opposite level, so that a leak would show as a decoding difference. Opening bursts and intervals are sized so that no stretch of 32 samples after an abandoned frame can reach 24 active samples.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SPACE,
        ST_MARK,
        ST_CHECK
    } rx_state_e;

endpackage

// File: rtl/ir_rx_window.sv
module ir_rx_window #(
    parameter int SAMPLE_W  = 12,
    parameter int THRESHOLD = 2048,
    parameter int WIN_LEN   = 32,
    localparam int ENERGY_W = $clog2(WIN_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_en,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                invert,
    output logic                active,
    output logic [ENERGY_W-1:0] energy
);

    localparam logic [SAMPLE_W-1:0] THRESH_V = SAMPLE_W'(THRESHOLD);

    logic [WIN_LEN-1:0] win_d, win_q;
    logic [WIN_LEN-1:0] shifted;

    always_comb begin
        active  = (sample_in > THRESH_V) ^ invert;
        shifted = {win_q[WIN_LEN-2:0], active};
        energy  = '0;
        for (int i = 0; i < WIN_LEN; i++) begin
            energy = energy + ENERGY_W'(shifted[i]);
        end
        win_d = sample_en ? shifted : win_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

endmodule

// File: rtl/ir_rx_crc8.sv
module ir_rx_crc8 #(
    parameter int               DATA_W = 16,
    parameter int               CRC_W  = 8,
    parameter logic [CRC_W-1:0] POLY   = 8'h07
) (
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);

    logic [CRC_W-1:0] acc;
    logic             fb;

    always_comb begin
        acc = '0;
        fb  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ data[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) acc = acc ^ POLY;
        end
        crc = acc;
    end

endmodule

// File: rtl/ir_frame_rx.sv
module ir_frame_rx #(
    parameter int         SAMPLE_W   = 12,
    parameter int         THRESHOLD  = 2048,
    parameter int         WIN_LEN    = 32,
    parameter int         HDR_MIN    = 24,
    parameter int         SETTLE_LEN = 10,
    parameter int         ONE_MIN    = 12,
    parameter int         ZERO_MIN   = 4,
    parameter int         MARK_MAX   = 12,
    parameter int         TYPE_W     = 3,
    parameter int         ID_W       = 8,
    parameter int         AMT_W      = 5,
    parameter int         CRC_W      = 8,
    parameter logic [7:0] CRC_POLY   = 8'h07,
    parameter int         HEAL_CODE  = 1,
    parameter int         TIMER_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_en,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                invert,
    output logic                frame_valid,
    output logic                crc_error,
    output logic [TYPE_W-1:0]   frame_type,
    output logic [ID_W-1:0]     frame_id,
    output logic [AMT_W-1:0]    frame_amount,
    output logic                frame_is_heal
);

    import ir_rx_pkg::*;

    localparam int FRAME_BITS = TYPE_W + ID_W + AMT_W + CRC_W;
    localparam int DATA_W     = FRAME_BITS - CRC_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int ENERGY_W   = $clog2(WIN_LEN + 1);

    localparam logic [ENERGY_W-1:0] HDR_MIN_E  = ENERGY_W'(HDR_MIN);
    localparam logic [TIMER_W-1:0]  SETTLE_END = TIMER_W'(SETTLE_LEN - 1);
    localparam logic [TIMER_W-1:0]  ONE_MIN_T  = TIMER_W'(ONE_MIN);
    localparam logic [TIMER_W-1:0]  ZERO_MIN_T = TIMER_W'(ZERO_MIN);
    localparam logic [TIMER_W-1:0]  MARK_MAX_T = TIMER_W'(MARK_MAX);
    localparam logic [TIMER_W-1:0]  TIMER_TOP  = '1;
    localparam logic [CNT_W-1:0]    LAST_BIT   = CNT_W'(FRAME_BITS - 1);
    localparam logic [TYPE_W-1:0]   HEAL_T     = TYPE_W'(HEAL_CODE);

    typedef struct packed {
        rx_state_e              st;
        logic [TIMER_W-1:0]     timer;
        logic [CNT_W-1:0]       bitcnt;
        logic [FRAME_BITS-1:0]  acc;
        logic [TYPE_W-1:0]      ftype;
        logic [ID_W-1:0]        fid;
        logic [AMT_W-1:0]       famt;
        logic                   heal;
        logic                   valid;
        logic                   err;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic                active;
    logic [ENERGY_W-1:0] energy;
    logic [CRC_W-1:0]    crc_calc;

    ir_rx_window #(
        .SAMPLE_W  (SAMPLE_W),
        .THRESHOLD (THRESHOLD),
        .WIN_LEN   (WIN_LEN)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .sample_in (sample_in),
        .invert    (invert),
        .active    (active),
        .energy    (energy)
    );

    ir_rx_crc8 #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_W'(CRC_POLY))
    ) u_crc (
        .data (r_q.acc[FRAME_BITS-1 -: DATA_W]),
        .crc  (crc_calc)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.err   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (sample_en && energy >= HDR_MIN_E) begin
                    r_d.st    = ST_SETTLE;
                    r_d.timer = '0;
                end
            end
            ST_SETTLE: begin
                if (sample_en) begin
                    if (r_q.timer == SETTLE_END) begin
                        r_d.st     = ST_SPACE;
                        r_d.timer  = '0;
                        r_d.bitcnt = '0;
                        r_d.acc    = '0;
                    end else begin
                        r_d.timer = r_q.timer + TIMER_W'(1);
                    end
                end
            end
            ST_SPACE: begin
                if (sample_en) begin
                    if (!active) begin
                        if (r_q.timer != TIMER_TOP) r_d.timer = r_q.timer + TIMER_W'(1);
                    end else if (r_q.timer < ZERO_MIN_T) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.acc    = {r_q.acc[FRAME_BITS-2:0], (r_q.timer >= ONE_MIN_T)};
                        r_d.bitcnt = r_q.bitcnt + CNT_W'(1);
                        r_d.timer  = '0;
                        r_d.st     = (r_q.bitcnt == LAST_BIT) ? ST_CHECK : ST_MARK;
                    end
                end
            end
            ST_MARK: begin
                if (sample_en) begin
                    if (active) begin
                        if (r_q.timer >= MARK_MAX_T) r_d.st = ST_IDLE;
                        else                         r_d.timer = r_q.timer + TIMER_W'(1);
                    end else begin
                        r_d.st    = ST_SPACE;
                        r_d.timer = '0;
                    end
                end
            end
            ST_CHECK: begin
                r_d.st    = ST_IDLE;
                r_d.ftype = r_q.acc[FRAME_BITS-1 -: TYPE_W];
                r_d.fid   = r_q.acc[FRAME_BITS-TYPE_W-1 -: ID_W];
                r_d.famt  = r_q.acc[CRC_W +: AMT_W];
                r_d.heal  = (r_q.acc[FRAME_BITS-1 -: TYPE_W] == HEAL_T);
                r_d.valid = (crc_calc == r_q.acc[CRC_W-1:0]);
                r_d.err   = (crc_calc != r_q.acc[CRC_W-1:0]);
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign frame_valid   = r_q.valid;
    assign crc_error     = r_q.err;
    assign frame_type    = r_q.ftype;
    assign frame_id      = r_q.fid;
    assign frame_amount  = r_q.famt;
    assign frame_is_heal = r_q.heal;

endmodule

// File: rtl/ir_frame_rx_chk.sv
module ir_frame_rx_chk #(
    parameter int TYPE_W   = 3,
    parameter int ID_W     = 8,
    parameter int AMT_W    = 5,
    parameter int TIMER_W  = 8,
    parameter int CNT_W    = 5,
    parameter int MARK_MAX = 12,
    parameter int NBITS    = 24,
    parameter int HEAL_CODE = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_en,
    input logic                 frame_valid,
    input logic                 crc_error,
    input logic [TYPE_W-1:0]    frame_type,
    input logic [ID_W-1:0]      frame_id,
    input logic [AMT_W-1:0]     frame_amount,
    input logic                 frame_is_heal,
    input ir_rx_pkg::rx_state_e st,
    input logic [TIMER_W-1:0]   timer,
    input logic [CNT_W-1:0]     bitcnt
);

    import ir_rx_pkg::*;

    // R8 / R9: at most one verdict per frame
    p_verdict_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_valid && crc_error));

    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    p_error_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |=> !crc_error);

    // R9: fields move only together with a verdict pulse
    p_fields_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_valid && !crc_error) |-> $stable({frame_type, frame_id, frame_amount, frame_is_heal}));

    // R8: a verdict only follows the check state
    p_verdict_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid || crc_error) |-> $past(st) == ST_CHECK);

    // R10: a stalled clock freezes the decoder
    p_stall_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && st != ST_CHECK) |=> $stable({st, timer, bitcnt}));

    // R6: carrier-on count never passes its bound
    p_mark_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_MARK |-> timer <= TIMER_W'(MARK_MAX));

    // R7: bit counter never passes the frame length
    p_bit_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= CNT_W'(NBITS));

    // R12: heal flag agrees with latched category
    p_heal_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_is_heal == (frame_type == TYPE_W'(HEAL_CODE)));

endmodule

bind ir_frame_rx ir_frame_rx_chk #(
    .TYPE_W    (TYPE_W),
    .ID_W      (ID_W),
    .AMT_W     (AMT_W),
    .TIMER_W   (TIMER_W),
    .CNT_W     (CNT_W),
    .MARK_MAX  (MARK_MAX),
    .NBITS     (FRAME_BITS),
    .HEAL_CODE (HEAL_CODE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_en     (sample_en),
    .frame_valid   (frame_valid),
    .crc_error     (crc_error),
    .frame_type    (frame_type),
    .frame_id      (frame_id),
    .frame_amount  (frame_amount),
    .frame_is_heal (frame_is_heal),
    .st            (r_q.st),
    .timer         (r_q.timer),
    .bitcnt        (r_q.bitcnt)
);

// File: tb/ir_frame_rx_bench.sv
module ir_frame_rx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_en = 1'b0;
    logic [11:0] sample_in = '0;
    logic        invert = 1'b0;
    logic        frame_valid, crc_error, frame_is_heal;
    logic [2:0]  frame_type;
    logic [7:0]  frame_id;
    logic [4:0]  frame_amount;

    always #5 clk = ~clk;

    ir_frame_rx u_ir_frame_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_en     (sample_en),
        .sample_in     (sample_in),
        .invert        (invert),
        .frame_valid   (frame_valid),
        .crc_error     (crc_error),
        .frame_type    (frame_type),
        .frame_id      (frame_id),
        .frame_amount  (frame_amount),
        .frame_is_heal (frame_is_heal)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int valid_seen = 0;
    int err_seen   = 0;
    logic [11:0] lvl_hi = 12'hFFF;
    logic [11:0] lvl_lo = 12'h000;
    int stall = 0;
    bit done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_valid) valid_seen++;
            if (crc_error)   err_seen++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_ref(input logic [15:0] d);
        logic [7:0] c = 8'h00;
        for (int i = 15; i >= 0; i--) begin
            logic fb = c[7] ^ d[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    function automatic logic [23:0] make_word(input logic [2:0] t, input logic [7:0] id, input logic [4:0] amt);
        logic [15:0] hi = {t, id, amt};
        return {hi, crc_ref(hi)};
    endfunction

    task automatic put(input bit act);
        sample_in = act ? lvl_hi : lvl_lo;
        sample_en = 1'b1;
        @(negedge clk);
        for (int s = 0; s < stall; s++) begin
            sample_en = 1'b0;
            sample_in = act ? lvl_lo : lvl_hi;
            @(negedge clk);
        end
        sample_en = 1'b0;
    endtask

    // measured gap m: sent as m+2 for the first bit (settle eats 2), m+1 later
    task automatic send_frame(input logic [23:0] w, input int hdr, input int m1, input int m0, input int mark);
        for (int i = 0; i < hdr; i++) put(1'b1);
        for (int b = 0; b < 24; b++) begin
            int m = w[23-b] ? m1 : m0;
            int n = m + ((b == 0) ? 2 : 1);
            for (int i = 0; i < n; i++) put(1'b0);
            for (int i = 0; i < mark; i++) put(1'b1);
        end
        for (int i = 0; i < 40; i++) put(1'b0);
    endtask

    task automatic expect_result(input string req, input int dv, input int de, input int v0, input int e0);
        chk(valid_seen - v0 == dv, {req, " valid pulses"}, valid_seen - v0, dv);
        chk(err_seen - e0 == de, {req, " error pulses"}, err_seen - e0, de);
    endtask

    task automatic expect_fields(input string req, input logic [23:0] w);
        chk(frame_type == w[23:21], {req, " type"}, frame_type, w[23:21]);
        chk(frame_id == w[20:13], {req, " id"}, frame_id, w[20:13]);
        chk(frame_amount == w[12:8], {req, " amount"}, frame_amount, w[12:8]);
    endtask

    task automatic t_reset();
        chk(frame_valid == 1'b0 && crc_error == 1'b0, "R11 pulses", {frame_valid, crc_error}, 0);
        chk({frame_type, frame_id, frame_amount, frame_is_heal} == '0, "R11 fields",
            {frame_type, frame_id, frame_amount, frame_is_heal}, 0);
    endtask

    task automatic t_heal();
        logic [23:0] w = make_word(3'd1, 8'd42, 5'd23);
        int v0 = valid_seen, e0 = err_seen;
        send_frame(w, 32, 14, 8, 6);
        expect_result("R8 heal frame", 1, 0, v0, e0);
        expect_fields("R7 heal frame", w);
        chk(frame_is_heal == 1'b1, "R12 heal flag set", frame_is_heal, 1);
    endtask

    task automatic t_other();
        logic [23:0] w = make_word(3'd5, 8'h9C, 5'h11);
        int v0 = valid_seen, e0 = err_seen;
        send_frame(w, 32, 14, 8, 6);
        expect_result("R8 other frame", 1, 0, v0, e0);
        expect_fields("R7 other frame", w);
        chk(frame_is_heal == 1'b0, "R12 heal flag clear", frame_is_heal, 0);
    endtask

    task automatic t_bad_crc();
        logic [23:0] w = make_word(3'd2, 8'd7, 5'd3) ^ 24'h000001;
        int v0 = valid_seen, e0 = err_seen;
        send_frame(w, 32, 14, 8, 6);
        expect_result("R9 bad check byte", 0, 1, v0, e0);
        expect_fields("R9 fields on error", w);
    endtask

    task automatic t_space_edges();
        logic [23:0] w = make_word(3'd6, 8'hA5, 5'h1F);
        int v0 = valid_seen, e0 = err_seen;
        send_frame(w, 32, 12, 11, 6);
        expect_result("R4 gaps 12/11 and R3 settle", 1, 0, v0, e0);
        expect_fields("R4 gaps 12/11", w);
        w = make_word(3'd4, 8'h3C, 5'h0A);
        v0 = valid_seen; e0 = err_seen;
        send_frame(w, 32, 12, 4, 6);
        expect_result("R4 gap 4 as zero", 1, 0, v0, e0);
        expect_fields("R4 gap 4 as zero", w);
    endtask

    task automatic t_glitch();
        logic [23:0] w = make_word(3'd0, 8'h12, 5'h05);
        int v0 = valid_seen, e0 = err_seen;
        send_frame(w, 32, 14, 3, 6);
        expect_result("R5 gap 3 abandons", 0, 0, v0, e0);
        w = make_word(3'd1, 8'h77, 5'h02);
        v0 = valid_seen; e0 = err_seen;
        send_frame(w, 32, 14, 8, 6);
        expect_result("R5 recovery", 1, 0, v0, e0);
        expect_fields("R5 recovery", w);
    endtask

    task automatic t_mark();
        logic [23:0] w = make_word(3'd3, 8'h55, 5'd9);
        int v0 = valid_seen, e0 = err_seen;
        send_frame(w, 32, 14, 8, 13);
        expect_result("R6 mark 13 kept", 1, 0, v0, e0);
        expect_fields("R6 mark 13 kept", w);
        v0 = valid_seen; e0 = err_seen;
        send_frame(w, 32, 14, 8, 14);
        expect_result("R6 mark 14 abandons", 0, 0, v0, e0);
    endtask

    task automatic t_invert();
        logic [23:0] w = make_word(3'd7, 8'hE1, 5'h14);
        int v0 = valid_seen, e0 = err_seen;
        invert = 1'b1; lvl_hi = 12'h000; lvl_lo = 12'hFFF;
        send_frame(w, 32, 14, 8, 6);
        expect_result("R1 inverted polarity", 1, 0, v0, e0);
        expect_fields("R1 inverted polarity", w);
        invert = 1'b0; lvl_hi = 12'hFFF; lvl_lo = 12'h000;
    endtask

    task automatic t_threshold();
        logic [23:0] w = make_word(3'd2, 8'h81, 5'h1E);
        int v0 = valid_seen, e0 = err_seen;
        lvl_hi = 12'd2049; lvl_lo = 12'd2048;
        send_frame(w, 32, 14, 8, 6);
        expect_result("R1 2049 active 2048 not", 1, 0, v0, e0);
        expect_fields("R1 threshold edge", w);
        v0 = valid_seen; e0 = err_seen;
        lvl_hi = 12'd2048;
        send_frame(w, 32, 14, 8, 6);
        expect_result("R1 2048 never active", 0, 0, v0, e0);
        lvl_hi = 12'hFFF; lvl_lo = 12'h000;
    endtask

    task automatic t_stall();
        logic [23:0] w = make_word(3'd1, 8'hC3, 5'h0F);
        int v0 = valid_seen, e0 = err_seen;
        stall = 3;
        send_frame(w, 32, 14, 8, 6);
        stall = 0;
        expect_result("R10 stalls ignored", 1, 0, v0, e0);
        expect_fields("R10 stalls ignored", w);
    endtask

    task automatic t_short_header();
        logic [23:0] w = make_word(3'd5, 8'h44, 5'h06);
        int v0 = valid_seen, e0 = err_seen;
        send_frame(w, 23, 14, 8, 6);
        expect_result("R2 23 active no burst", 0, 0, v0, e0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #1500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_heal();
        t_other();
        t_bad_crc();
        t_space_edges();
        t_glitch();
        t_mark();
        t_invert();
        t_threshold();
        t_stall();
        t_short_header();
        finish_run();
    end

endmodule